// File: doc/BRIEF.md
# Capture Timer with Event Divider and Capture FIFO

This block runs a 16-bit free-running up-counter and records its value whenever a capture strobe arrives. The recorded timestamps go into a four-entry first-in first-out store. Software or downstream logic drains this store through a simple read port. Timestamps from several sources can be compared because they all come from one shared time base.

An optional event divider thins the strobe stream. When it is switched on, only every Nth strobe records a timestamp, with N anywhere from 2 to 127. N may be rewritten while the block runs. A level interrupt goes high once the store holds at least a chosen number of entries, from one to four. A sticky overflow flag reports strobes that found the store full.

Top module: `cap_timer_queue`

## Requirements
- R1: After reset the counter on `cnt_o` reads 0 and advances by one on every clock, wrapping from 65535 to 0.
- R2: With `psc_en_i` low, every cycle with `cap_i` high stores the value `cnt_o` shows in that same cycle. The entry becomes readable in the following cycle.
- R3: With `psc_en_i` high, only the Nth strobe stores a value, where N is `psc_n_i`; codes 0 and 1 act as 2. The strobe tally restarts at zero after each storing strobe, and it is held at zero while `psc_en_i` is low.
- R4: N is read on each strobe. A strobe stores when the tally including itself is at least the current N, so a run-time change applies from the next strobe.
- R5: The store is a four-entry FIFO. The oldest entry appears on `rd_data_o` with `rd_valid_o` high, and `rd_i` removes it. `rd_i` on an empty store has no effect. `empty_o` is high at zero entries and `full_o` at four.
- R6: A storing strobe that finds the store full is dropped, unless `rd_i` removes an entry in the same cycle. A drop sets `ovf_o`, which stays high until `ovf_clr_i`; a drop and a clear in the same cycle leave it set.
- R7: `irq_o` is high while the number of held entries is at least `irq_thr_i`+1. The codes 0 to 3 select 1 to 4 entries.
- R8: During and just after reset the store is empty, `full_o`, `rd_valid_o`, `ovf_o` and `irq_o` are low, and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Capture strobe, one pulse per event |
| psc_en_i | input | 1 | Event divider enable |
| psc_n_i | input | 7 | Divider ratio N (0 and 1 act as 2) |
| irq_thr_i | input | 2 | Interrupt threshold code, entries minus one |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| rd_i | input | 1 | Removes the oldest entry |
| rd_data_o | output | 16 | Oldest stored timestamp |
| rd_valid_o | output | 1 | `rd_data_o` holds an entry |
| empty_o | output | 1 | Store holds no entries |
| full_o | output | 1 | Store holds four entries |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Threshold interrupt level |
| cnt_o | output | 16 | Current counter value |

## Verification
Random strobes and reads are applied with the divider off and with it on. The first case separates a wrong latch cycle from a correct one. The second exposes an off-by-one in the tally. Ratio codes 0, 1, 2 and 127 are forced directly, and the ratio is also changed mid-count, which checks the clamp and the `at least` rule. Long strobe bursts with few reads fill the store and check the drop rule, the sticky flag and simultaneous read and write when full. Over 65536 cycles of run time the counter wraps, and the test confirms that timestamps taken across the wrap are stored correctly.

// File: rtl/cap_timer_queue.sv
module cap_timer_queue #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  parameter int PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             psc_en_i,
  input  logic [PSC_W-1:0] psc_n_i,
  input  logic [$clog2(DEPTH)-1:0] irq_thr_i,
  input  logic             ovf_clr_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int EW = PSC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [LW-1:0]    level_q;
  logic [PSC_W-1:0] ev_q;
  logic             ovf_q;
  logic             run_q;

  logic [EW-1:0]    n_eff, ev_inc;
  logic             qual, pop, push, drop;

  assign n_eff  = (psc_n_i < PSC_W'(2)) ? EW'(2) : EW'(psc_n_i);
  assign ev_inc = EW'(ev_q) + EW'(1);
  assign qual   = cap_i && (!psc_en_i || ev_inc >= n_eff);
  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == LW'(DEPTH));
  assign pop    = rd_i && !empty_o;
  assign push   = qual && (!full_o || pop);
  assign drop   = qual && full_o && !pop;

  assign rd_data_o  = mem_q[rd_ptr_q];
  assign rd_valid_o = !empty_o;
  assign ovf_o      = ovf_q;
  assign irq_o      = level_q > LW'(irq_thr_i);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ev_q <= '0;
    else if (!psc_en_i)
      ev_q <= '0;
    else if (cap_i)
      ev_q <= qual ? '0 : ev_inc[PSC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + PW'(1);
      case ({push, pop})
        2'b10:   level_q <= level_q + LW'(1);
        2'b01:   level_q <= level_q - LW'(1);
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (drop)     ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !cap_i) |=> empty_o);

  a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !rd_i) |=> full_o);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_i) ##1 $stable(irq_thr_i) |-> irq_o);

  a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o) && (rd_valid_o != empty_o));

endmodule

// File: tb/cap_timer_queue_bench.sv
module cap_timer_queue_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_i = 1'b0, psc_en_i = 1'b0, ovf_clr_i = 1'b0, rd_i = 1'b0;
  logic [6:0]  psc_n_i = 7'd2;
  logic [1:0]  irq_thr_i = 2'd0;
  logic [15:0] rd_data_o, cnt_o;
  logic        rd_valid_o, empty_o, full_o, ovf_o, irq_o;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  logic [15:0] m_cnt;
  logic [15:0] m_q[$];
  int          m_ev;
  bit          m_ovf;

  cap_timer_queue u_cap_timer_queue (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .psc_en_i(psc_en_i),
    .psc_n_i(psc_n_i), .irq_thr_i(irq_thr_i), .ovf_clr_i(ovf_clr_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .empty_o(empty_o), .full_o(full_o), .ovf_o(ovf_o), .irq_o(irq_o),
    .cnt_o(cnt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_n(input logic [6:0] n);
    return (n < 7'd2) ? 2 : int'(n);
  endfunction

  function automatic bit exp_irq(input int lvl, input logic [1:0] thr);
    return lvl >= int'(thr) + 1;
  endfunction

  task automatic compare(input string tag);
    int sz = m_q.size();
    chk(cnt_o == m_cnt, "R1 cnt", cnt_o, m_cnt);
    chk(empty_o == (sz == 0), {"R5 empty ", tag}, empty_o, sz == 0);
    chk(full_o == (sz == 4), {"R5 full ", tag}, full_o, sz == 4);
    chk(rd_valid_o == (sz != 0), {"R5 valid ", tag}, rd_valid_o, sz != 0);
    if (sz != 0) chk(rd_data_o == m_q[0], {"R2/R3 data ", tag}, rd_data_o, m_q[0]);
    chk(irq_o == exp_irq(sz, irq_thr_i), {"R7 irq ", tag}, irq_o, exp_irq(sz, irq_thr_i));
    chk(ovf_o == m_ovf, {"R6 ovf ", tag}, ovf_o, m_ovf);
  endtask

  task automatic cycle(input bit cap, input bit rd, input bit clr, input string tag);
    bit qual, pop, full;
    cap_i = cap; rd_i = rd; ovf_clr_i = clr;
    qual = cap && (!psc_en_i || (m_ev + 1 >= eff_n(psc_n_i)));
    pop  = rd && (m_q.size() != 0);
    full = (m_q.size() == 4);
    if (pop) void'(m_q.pop_front());
    if (qual && (!full || pop)) m_q.push_back(m_cnt);
    if (qual && full && !pop) m_ovf = 1;
    else if (clr) m_ovf = 0;
    if (!psc_en_i) m_ev = 0;
    else if (cap) m_ev = qual ? 0 : m_ev + 1;
    m_cnt = m_cnt + 16'd1;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_cnt = 0; m_ev = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    compare("R8 in reset");
    rst_n = 1'b1;
    compare("R8 after release");

    // R2: strobes with divider off, fill to overflow
    irq_thr_i = 2'd3;
    for (int i = 0; i < 6; i++) cycle(1, 0, 0, "R2 burst");
    cycle(1, 1, 0, "R6 push+pop when full");
    cycle(0, 0, 1, "R6 clear");
    for (int i = 0; i < 4; i++) cycle(0, 1, 0, "R5 drain");
    cycle(0, 1, 0, "R5 read empty ignored");

    // R3: clamp codes 0 and 1, and extreme 127
    psc_en_i = 1;
    psc_n_i = 7'd0;
    for (int i = 0; i < 5; i++) cycle(1, 0, 0, "R3 code0");
    psc_n_i = 7'd1;
    for (int i = 0; i < 4; i++) cycle(1, 1, 0, "R3 code1");
    psc_n_i = 7'd127;
    for (int i = 0; i < 260; i++) cycle(1, 1, 0, "R3 n127");
    // R4: lower N mid-tally
    psc_n_i = 7'd10;
    for (int i = 0; i < 6; i++) cycle(1, 0, 0, "R4 tally");
    psc_n_i = 7'd3;
    cycle(1, 0, 0, "R4 lowered N");
    cycle(1, 0, 0, "R4 after change");
    psc_en_i = 0;
    cycle(0, 0, 0, "R3 tally held");

    // random phase, runs past a counter wrap (R1)
    for (int i = 0; i < 70000; i++) begin
      if ($urandom_range(0, 499) == 0) psc_en_i = ~psc_en_i;
      if ($urandom_range(0, 199) == 0) begin
        case ($urandom_range(0, 4))
          0: psc_n_i = 7'd0;
          1: psc_n_i = 7'd1;
          2: psc_n_i = 7'd127;
          default: psc_n_i = 7'($urandom_range(2, 6));
        endcase
      end
      if ($urandom_range(0, 99) == 0) irq_thr_i = 2'($urandom_range(0, 3));
      cycle($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
            $urandom_range(0, 49) == 0, "random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule